// File: doc/BRIEF.md
# Gated Stream Packetizer with Status Readback

This block sits on the output side of a radar receive chain. It turns one processed sample set (a range word, a Doppler word and a detection-flag word) into a framed packet on a word stream with a valid/ready handshake. A three-bit enable mask lives in a configuration clock domain and passes through a synchronizer into the output clock domain. It decides at run time which of the three sections go into each packet. The header and footer are always sent.

The configuration domain can also ask for a status report. Each request pulse flips a toggle bit. The output domain synchronizes that bit and turns each edge into a pending request. When the packet engine is idle, it answers with a fixed seven-word status packet. That packet reports the enable mask, the detection threshold, the radar mode, five chirp timing values and the chirps-per-elevation count. These values are captured as one snapshot when the status packet starts.

Top module: `gated_stream_packetizer`

## Requirements
- R1: While `rstN` is low and right after reset, `outValid` is 0 and `sampleReady` is 1. The mask synchronizer resets to all sections enabled (3'b111).
- R2: A sample set accepted with all mask bits set produces exactly five words: 0x000000AA, range, Doppler, detection flags, 0x00000055.
- R3: Mask bit 0 enables the range word, bit 1 the Doppler word and bit 2 the detection word. A section whose bit is clear is left out, and the other words keep their relative order.
- R4: When the synchronized mask is 3'b000, an accepted sample set is dropped and no word appears on the output. Status requests are still answered, and word 1 then reports a mask of 0.
- R5: A status packet is seven words: 0x000000BB; then {threshold[15:0], 11'b0, mode[1:0], mask[2:0]}; then long chirp zero-extended; then long listen zero-extended; then {guard, short chirp}; then {short listen, 10'b0, chirps-per-elevation[5:0]}; then 0x00000055. Every packet starts with 0xAA or 0xBB after at least one idle cycle.
- R6: Each `cfgStatusReq` pulse in the configuration domain causes one status packet in the output domain. This holds when requests are spaced far enough apart that each toggle edge is seen on its own.
- R7: A status request that arrives during a data packet does not interrupt it. The status packet follows once that packet's footer has been taken.
- R8: While a status request is pending, `sampleReady` is 0, so a waiting status packet is sent before the next sample set is accepted.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` does not change.
- R10: The status words carry the configuration values as they were when the status packet started. Later changes to those inputs do not alter the packet already under way.
- R11: `sampleReady` is 1 only while no packet is being sent. No sample set is accepted while `outValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rstN | input | 1 | Output-domain asynchronous reset, active low |
| cfgClk | input | 1 | Configuration-domain clock |
| cfgRstN | input | 1 | Configuration-domain asynchronous reset, active low |
| cfgStreamMask | input | 3 | Section enable mask (bit0 range, bit1 Doppler, bit2 detection), configuration domain |
| cfgStatusReq | input | 1 | One-cycle status request pulse, configuration domain |
| sampleValid | input | 1 | A sample set is offered |
| sampleReady | output | 1 | The sample set is taken on this edge when valid |
| rangeIn | input | WORD_W | Range word of the sample set |
| dopplerIn | input | WORD_W | Doppler word of the sample set |
| detectIn | input | WORD_W | Detection-flag word of the sample set |
| detThreshold | input | 16 | Detection threshold, reported in status |
| radarMode | input | 2 | Radar mode, reported in status |
| longChirpLen | input | 16 | Long chirp length in cycles |
| longListenLen | input | 16 | Long listen length in cycles |
| guardLen | input | 16 | Guard length in cycles |
| shortChirpLen | input | 16 | Short chirp length in cycles |
| shortListenLen | input | 16 | Short listen length in cycles |
| chirpsPerElev | input | 6 | Chirps per elevation step |
| outData | output | WORD_W | Output word |
| outValid | output | 1 | Output word is valid |
| outReady | input | 1 | Sink accepts the output word |

## Verification
The properties assume the configuration side changes the enable mask only between packets and that status requests are spaced so the destination sees each toggle edge on its own. The timing and threshold inputs are assumed to stay fixed while a status snapshot is being loaded. The bench respects these assumptions: it waits several output cycles after each mask change and waits for each status packet to be consumed before the next request. It also changes configuration values only after the status header has appeared. `outReady` is driven held high, held low, and in a pseudo-random pattern, and it may fall at any cycle.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int MASK_W     = 3;
  localparam int TIME_W     = 16;
  localparam int THR_W      = 16;
  localparam int MODE_W     = 2;
  localparam int CPE_W      = 6;
  localparam int STATUS_LEN = 7;
  localparam int SNAP_WORDS = STATUS_LEN - 2;
  localparam int RANGE_BIT  = 0;
  localparam int DOPP_BIT   = 1;
  localparam int DET_BIT    = 2;
  localparam logic [7:0] DATA_HDR = 8'hAA;
  localparam logic [7:0] STAT_HDR = 8'hBB;
  localparam logic [7:0] PKT_FOOT = 8'h55;
  localparam logic [2:0] LAST_IDX = 3'(STATUS_LEN - 1);

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HEADER  = 3'd1,
    ST_RANGE   = 3'd2,
    ST_DOPPLER = 3'd3,
    ST_DETECT  = 3'd4,
    ST_FOOTER  = 3'd5,
    ST_STATUS  = 3'd7
  } fsmState_e;

  typedef enum logic [2:0] {
    SEL_HDR, SEL_RANGE, SEL_DOPP, SEL_DET, SEL_FOOT, SEL_STAT
  } wordSel_e;

  typedef struct packed {
    logic       loadSample;
    logic       loadStatus;
    wordSel_e   sel;
    logic [2:0] statIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/gsp_cdc.sv
module gsp_cdc #(
  parameter int SYNC_STAGES = 2,
  parameter int MASK_W      = 3,
  parameter logic [MASK_W-1:0] MASK_RST = '1
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [MASK_W-1:0] srcMask,
  input  logic              srcReq,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [MASK_W-1:0] dstMask,
  output logic              dstReqPulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic              reqToggle;
  logic [MASK_W-1:0] maskStage [SYNC_STAGES];
  logic              togStage  [SYNC_STAGES];
  logic              togSeen;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)    reqToggle <= 1'b0;
    else if (srcReq) reqToggle <= ~reqToggle;
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        maskStage[s] <= MASK_RST;
        togStage[s]  <= 1'b0;
      end
      togSeen <= 1'b0;
    end else begin
      maskStage[0] <= srcMask;
      togStage[0]  <= reqToggle;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        maskStage[s] <= maskStage[s-1];
        togStage[s]  <= togStage[s-1];
      end
      togSeen <= togStage[LAST];
    end
  end

  assign dstMask     = maskStage[LAST];
  assign dstReqPulse = togStage[LAST] ^ togSeen;
endmodule

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
  import gsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MASK_W-1:0] streamMask,
  input  logic              reqPulse,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic              outReady,
  output logic              outValid,
  output logic              statusPending,
  output ctrlStrobes_t      strobes
);
  fsmState_e  state, nextState;
  logic [2:0] statIdx, nextIdx;
  logic       takeStatus, fire;

  function automatic fsmState_e firstEnabled(input logic [MASK_W-1:0] m);
    if (m[RANGE_BIT])     return ST_RANGE;
    else if (m[DOPP_BIT]) return ST_DOPPLER;
    else if (m[DET_BIT])  return ST_DETECT;
    else                  return ST_FOOTER;
  endfunction

  assign outValid    = (state != ST_IDLE);
  assign sampleReady = (state == ST_IDLE) && !statusPending;
  assign fire        = outValid && outReady;

  always_comb begin
    nextState          = state;
    nextIdx            = statIdx;
    takeStatus         = 1'b0;
    strobes.loadSample = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (statusPending) begin
          takeStatus = 1'b1;
          nextIdx    = '0;
          nextState  = ST_STATUS;
        end else if (sampleValid && (streamMask != '0)) begin
          strobes.loadSample = 1'b1;
          nextState          = ST_HEADER;
        end
      end
      ST_HEADER:  if (fire) nextState = firstEnabled(streamMask);
      ST_RANGE:   if (fire) nextState = firstEnabled({streamMask[DET_BIT], streamMask[DOPP_BIT], 1'b0});
      ST_DOPPLER: if (fire) nextState = firstEnabled({streamMask[DET_BIT], 2'b00});
      ST_DETECT:  if (fire) nextState = ST_FOOTER;
      ST_FOOTER:  if (fire) nextState = ST_IDLE;
      ST_STATUS: begin
        if (fire) begin
          if (statIdx == LAST_IDX) nextState = ST_IDLE;
          else                     nextIdx   = statIdx + 3'd1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.loadStatus = takeStatus;
    strobes.statIdx    = statIdx;
    unique case (state)
      ST_RANGE:   strobes.sel = SEL_RANGE;
      ST_DOPPLER: strobes.sel = SEL_DOPP;
      ST_DETECT:  strobes.sel = SEL_DET;
      ST_FOOTER:  strobes.sel = SEL_FOOT;
      ST_STATUS:  strobes.sel = SEL_STAT;
      default:    strobes.sel = SEL_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      statIdx       <= '0;
      statusPending <= 1'b0;
    end else begin
      state         <= nextState;
      statIdx       <= nextIdx;
      statusPending <= (statusPending && !takeStatus) || reqPulse;
    end
  end
endmodule

// File: rtl/gsp_datapath.sv
module gsp_datapath
  import gsp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] rangeIn,
  input  logic [WORD_W-1:0] dopplerIn,
  input  logic [WORD_W-1:0] detectIn,
  input  logic [MASK_W-1:0] streamMask,
  input  logic [THR_W-1:0]  detThreshold,
  input  logic [MODE_W-1:0] radarMode,
  input  logic [TIME_W-1:0] longChirpLen,
  input  logic [TIME_W-1:0] longListenLen,
  input  logic [TIME_W-1:0] guardLen,
  input  logic [TIME_W-1:0] shortChirpLen,
  input  logic [TIME_W-1:0] shortListenLen,
  input  logic [CPE_W-1:0]  chirpsPerElev,
  output logic [WORD_W-1:0] outData
);
  localparam int PAD0_W = 2 * TIME_W - THR_W - MODE_W - MASK_W;
  localparam int PAD4_W = 2 * TIME_W - TIME_W - CPE_W;

  logic [WORD_W-1:0] rangeReg, dopplerReg, detectReg;
  logic [WORD_W-1:0] liveWords [SNAP_WORDS];
  logic [WORD_W-1:0] snapWords [SNAP_WORDS];

  always_comb begin
    liveWords[0] = WORD_W'({detThreshold, {PAD0_W{1'b0}}, radarMode, streamMask});
    liveWords[1] = WORD_W'(longChirpLen);
    liveWords[2] = WORD_W'(longListenLen);
    liveWords[3] = WORD_W'({guardLen, shortChirpLen});
    liveWords[4] = WORD_W'({shortListenLen, {PAD4_W{1'b0}}, chirpsPerElev});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeReg   <= '0;
      dopplerReg <= '0;
      detectReg  <= '0;
    end else if (strobes.loadSample) begin
      rangeReg   <= rangeIn;
      dopplerReg <= dopplerIn;
      detectReg  <= detectIn;
    end
  end

  generate
    for (genvar w = 0; w < SNAP_WORDS; w++) begin : g_snap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   snapWords[w] <= '0;
        else if (strobes.loadStatus) snapWords[w] <= liveWords[w];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobes.sel)
      SEL_RANGE: outData = rangeReg;
      SEL_DOPP:  outData = dopplerReg;
      SEL_DET:   outData = detectReg;
      SEL_FOOT:  outData = WORD_W'(PKT_FOOT);
      SEL_STAT: begin
        case (strobes.statIdx)
          3'd0:    outData = WORD_W'(STAT_HDR);
          3'd1:    outData = snapWords[0];
          3'd2:    outData = snapWords[1];
          3'd3:    outData = snapWords[2];
          3'd4:    outData = snapWords[3];
          3'd5:    outData = snapWords[4];
          default: outData = WORD_W'(PKT_FOOT);
        endcase
      end
      default:   outData = WORD_W'(DATA_HDR);
    endcase
  end
endmodule

// File: rtl/gated_stream_packetizer.sv
module gated_stream_packetizer
  import gsp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgClk,
  input  logic              cfgRstN,
  input  logic [2:0]        cfgStreamMask,
  input  logic              cfgStatusReq,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic [WORD_W-1:0] rangeIn,
  input  logic [WORD_W-1:0] dopplerIn,
  input  logic [WORD_W-1:0] detectIn,
  input  logic [15:0]       detThreshold,
  input  logic [1:0]        radarMode,
  input  logic [15:0]       longChirpLen,
  input  logic [15:0]       longListenLen,
  input  logic [15:0]       guardLen,
  input  logic [15:0]       shortChirpLen,
  input  logic [15:0]       shortListenLen,
  input  logic [5:0]        chirpsPerElev,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);
  logic [MASK_W-1:0] maskSync;
  logic              reqPulse;
  logic              statusPending;
  ctrlStrobes_t      strobes;

  gsp_cdc #(
    .SYNC_STAGES(SYNC_STAGES),
    .MASK_W     (MASK_W),
    .MASK_RST   ('1)
  ) i_cdc (
    .srcClk     (cfgClk),
    .srcRstN    (cfgRstN),
    .srcMask    (cfgStreamMask),
    .srcReq     (cfgStatusReq),
    .dstClk     (clk),
    .dstRstN    (rstN),
    .dstMask    (maskSync),
    .dstReqPulse(reqPulse)
  );

  gsp_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .streamMask   (maskSync),
    .reqPulse     (reqPulse),
    .sampleValid  (sampleValid),
    .sampleReady  (sampleReady),
    .outReady     (outReady),
    .outValid     (outValid),
    .statusPending(statusPending),
    .strobes      (strobes)
  );

  gsp_datapath #(.WORD_W(WORD_W)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .rangeIn       (rangeIn),
    .dopplerIn     (dopplerIn),
    .detectIn      (detectIn),
    .streamMask    (maskSync),
    .detThreshold  (detThreshold),
    .radarMode     (radarMode),
    .longChirpLen  (longChirpLen),
    .longListenLen (longListenLen),
    .guardLen      (guardLen),
    .shortChirpLen (shortChirpLen),
    .shortListenLen(shortListenLen),
    .chirpsPerElev (chirpsPerElev),
    .outData       (outData)
  );
endmodule

// File: rtl/gsp_chk.sv
module gsp_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              sampleReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic [2:0]        maskSync,
  input logic              statusPending
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R5
  pkt_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(outValid) |->
      (outData == WORD_W'(8'hAA)) || (outData == WORD_W'(8'hBB)));

  // R4
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && sampleReady && (maskSync == 3'b000) |=> !outValid);

  // R8
  status_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusPending |-> !sampleReady);

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> !outValid);
endmodule

bind gated_stream_packetizer gsp_chk #(.WORD_W(WORD_W)) i_gspChk (
  .clk          (clk),
  .rstN         (rstN),
  .sampleValid  (sampleValid),
  .sampleReady  (sampleReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outData      (outData),
  .maskSync     (maskSync),
  .statusPending(statusPending)
);

// File: tb/test_gated_stream_packetizer.sv
module test_gated_stream_packetizer;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_PERIOD = 14;
  localparam int WORD_W     = 32;

  logic clk = 0, cfgClk = 0, rstN = 0, cfgRstN = 0;
  logic [2:0] cfgStreamMask = 3'b111;
  logic cfgStatusReq = 0, sampleValid = 0, sampleReady, outValid, outReady = 0;
  logic [WORD_W-1:0] rangeIn = 0, dopplerIn = 0, detectIn = 0, outData;
  logic [15:0] detThreshold = 16'd10000, longChirpLen = 16'd3000, longListenLen = 16'd13700;
  logic [15:0] guardLen = 16'd17540, shortChirpLen = 16'd50, shortListenLen = 16'd17450;
  logic [1:0]  radarMode = 2'd1;
  logic [5:0]  chirpsPerElev = 6'd32;

  logic [2:0] curMask = 3'b111;
  int readyMode = 0;
  logic [7:0] lfsr = 8'h5A;
  int checks = 0, errors = 0, wordsSeen = 0;
  logic [WORD_W-1:0] expQ[$];
  string tagQ[$];
  logic bDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CFG_PERIOD/2) cfgClk = ~cfgClk;

  gated_stream_packetizer #(.WORD_W(WORD_W)) i_gated_stream_packetizer (
    .clk(clk), .rstN(rstN), .cfgClk(cfgClk), .cfgRstN(cfgRstN),
    .cfgStreamMask(cfgStreamMask), .cfgStatusReq(cfgStatusReq),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .rangeIn(rangeIn), .dopplerIn(dopplerIn), .detectIn(detectIn),
    .detThreshold(detThreshold), .radarMode(radarMode),
    .longChirpLen(longChirpLen), .longListenLen(longListenLen), .guardLen(guardLen),
    .shortChirpLen(shortChirpLen), .shortListenLen(shortListenLen),
    .chirpsPerElev(chirpsPerElev),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [WORD_W-1:0] w, input string tag);
    expQ.push_back(w);
    tagQ.push_back(tag);
  endtask

  // sink ready pattern, driven just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    case (readyMode)
      0: outReady = 1'b1;
      1: begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        outReady = lfsr[0];
      end
      default: outReady = 1'b0;
    endcase
  end

  // monitor: compares every transferred word with the scoreboard
  initial forever begin
    @(negedge clk);
    if (rstN && outValid && outReady) begin
      wordsSeen++;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected word actual %h expected none", outData);
      end else begin
        logic [WORD_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData === e, t, outData, e);
      end
    end
  end

  task automatic pushData(input logic [WORD_W-1:0] r, d, t, input string tag);
    if (curMask != 3'b000) begin
      push(WORD_W'(8'hAA), tag);
      if (curMask[0]) push(r, tag);
      if (curMask[1]) push(d, tag);
      if (curMask[2]) push(t, tag);
      push(WORD_W'(8'h55), tag);
    end
  endtask

  task automatic sendSample(input logic [WORD_W-1:0] r, d, t, input string tag);
    @(posedge clk); #2;
    sampleValid = 1; rangeIn = r; dopplerIn = d; detectIn = t;
    do @(negedge clk); while (!sampleReady);
    pushData(r, d, t, tag);
    @(posedge clk); #2;
    sampleValid = 0;
  endtask

  task automatic setMask(input logic [2:0] m);
    @(posedge cfgClk); #1;
    cfgStreamMask = m;
    curMask = m;
    repeat (8) @(posedge clk);
  endtask

  task automatic reqStatus(input string tag);
    push(WORD_W'(8'hBB), tag);
    push({detThreshold, 11'd0, radarMode, curMask}, tag);
    push({16'd0, longChirpLen}, tag);
    push({16'd0, longListenLen}, tag);
    push({guardLen, shortChirpLen}, tag);
    push({shortListenLen, 10'd0, chirpsPerElev}, tag);
    push(WORD_W'(8'h55), tag);
    @(posedge cfgClk); #1; cfgStatusReq = 1;
    @(posedge cfgClk); #1; cfgStatusReq = 0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    logic [WORD_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 0, "R1 outValid in reset", 32'(outValid), 0);
    check(sampleReady == 1, "R1 sampleReady in reset", 32'(sampleReady), 1);
    @(posedge clk); #2; rstN = 1; cfgRstN = 1;
    repeat (2) @(negedge clk);
    check(outValid == 0, "R1 outValid after reset", 32'(outValid), 0);
    check(sampleReady == 1, "R1 sampleReady after reset", 32'(sampleReady), 1);

    // R2 full packets
    readyMode = 0;
    sendSample(32'h1111_0001, 32'h2222_0002, 32'h3333_0003, "R2 full mask");
    sendSample(32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, "R2 full mask");
    drain();

    // R5 / R6 status packets, two separate requests
    reqStatus("R5 status layout");
    drain();
    detThreshold = 16'h1234; radarMode = 2'd3; chirpsPerElev = 6'd63;
    repeat (2) @(posedge clk);
    reqStatus("R6 second request");
    drain();

    // R3 gating per section
    setMask(3'b001); sendSample(32'hA1, 32'hA2, 32'hA3, "R3 range only");   drain();
    setMask(3'b010); sendSample(32'hB1, 32'hB2, 32'hB3, "R3 Doppler only"); drain();
    setMask(3'b100); sendSample(32'hC1, 32'hC2, 32'hC3, "R3 detect only");  drain();
    setMask(3'b101); sendSample(32'hD1, 32'hD2, 32'hD3, "R3 range+detect"); drain();
    setMask(3'b110); sendSample(32'hE1, 32'hE2, 32'hE3, "R3 no range");     drain();

    // R4 all sections off
    setMask(3'b000);
    seen = wordsSeen;
    sendSample(32'hF1, 32'hF2, 32'hF3, "R4 dropped");
    sendSample(32'hF4, 32'hF5, 32'hF6, "R4 dropped");
    repeat (20) @(negedge clk);
    check(wordsSeen == seen, "R4 no output when masked", 32'(wordsSeen), 32'(seen));
    reqStatus("R4 status with mask off");
    drain();

    // R9 random backpressure
    setMask(3'b111);
    readyMode = 1;
    for (int i = 0; i < 6; i++)
      sendSample(32'(i * 7 + 1), 32'(i * 7 + 2), 32'(i * 7 + 3), "R9 backpressure");
    drain();

    // R7 / R8 / R10 / R11 request during a stalled packet
    readyMode = 2;
    repeat (2) @(posedge clk);
    sendSample(32'h7070_0001, 32'h7070_0002, 32'h7070_0003, "R7 packet before status");
    reqStatus("R10 status snapshot");
    repeat (20) @(negedge clk);
    held = outData;
    check(outValid == 1 && outData == 32'hAA, "R9 stalled header", outData, 32'hAA);
    check(sampleReady == 0, "R11 not ready while sending", 32'(sampleReady), 0);
    fork begin
      sendSample(32'h8080_0001, 32'h8080_0002, 32'h8080_0003, "R8 sample after status");
      bDone = 1;
    end join_none
    repeat (5) @(negedge clk);
    check(outData == held, "R9 data stable while stalled", outData, held);
    check(sampleReady == 0, "R8 sample held off", 32'(sampleReady), 0);
    readyMode = 1;
    do @(negedge clk); while (!(outValid && outData == 32'hBB));
    detThreshold = 16'hFFFF; longChirpLen = 16'h0BAD; guardLen = 16'h0; chirpsPerElev = 6'd1;
    while (!bDone) @(negedge clk);
    drain();
    check(expQ.size() == 0, "R7 all words delivered", 32'(expQ.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule